// File: doc/BRIEF.md
# Multiple-Register Memory Transfer Sequencer

This block carries out a block move between a sixteen-entry register file and memory. The register file holds eight data registers at indices 0 to 7 and eight address registers at indices 8 to 15. A 16-bit select mask names the registers to move. A controller pulses `start` with three inputs: the instruction word, the mask extension word, and an effective address that an outside address unit has already worked out. For the register-indirect, postincrement and predecrement modes, that address equals the base register's current value.

The block then steps through the selected registers. Each transfer uses a request/acknowledge memory port and is either a 16-bit word or a 32-bit longword. It reads or writes the register file through plain read and write ports, and the register-file read returns data in the same cycle. In the postincrement and predecrement modes it writes the final address back to the base address register. It raises a fault for any combination of addressing mode, direction and size that is not allowed.

Two configuration inputs change its behaviour. One selects which value is stored when the base register is part of a predecrement store. The other restricts the block to a reduced instruction set.

Top module: `mrx_seq`

## Requirements
- R1: Instruction bit 10 set selects a load (memory to registers) and clear selects a store. Bit 6 set selects longword transfers (`mem_long`=1, address step 4) and clear selects word transfers (step 2).
- R2: The mode is instruction bits 5:3 and the base register is bits 2:0. Modes 0 and 1 produce a one-cycle `fault`, with no memory request, no register write and no `done`.
- R3: Mode 3 (postincrement) combined with a store faults. Mode 4 (predecrement) combined with a load faults. Both behave as in R2.
- R4: With `cfg_restricted`=1, only longword transfers in mode 2 or mode 5 are accepted. Any other size or mode faults.
- R5: Outside mode 4, mask bit i selects register-file index i. Transfers run from the lowest selected index upward, at addresses `ea`, `ea`+step, and so on.
- R6: A load issues every memory read before it makes any register write. It then writes the selected registers in ascending index order. A word read is sign-extended from bit 15 to 32 bits.
- R7: A load in mode 3 writes `ea` + n×step to index 8+base, where n is the number of selected registers. This write comes after the loaded registers are written.
- R8: In a mode-4 store, mask bit 15−i selects index i. The walk runs from index 15 down to 0. The address is decremented before each store, so the first store goes to `ea`−step. Afterwards `ea` − n×step is written to index 8+base.
- R9: In a mode-4 store that includes the base register, the value stored for it is the base register's initial value when `cfg_later_gen`=0. When `cfg_later_gen`=1 it is that initial value minus the step.
- R10: An all-zero mask makes no memory access and no register write, including the base write-back. The block still gives `done`.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a one-cycle pulse that follows the last register write. A `start` that arrives while `busy` is high is ignored.
- R12: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` held, until the cycle in which `mem_ack` is high.
- R13: A word store places the register's low 16 bits on `mem_wdata[15:0]` and drives `mem_wdata[31:16]` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| insn | input | 16 | Instruction word |
| mask | input | 16 | Register select mask |
| ea | input | 32 | Precomputed effective address |
| cfg_later_gen | input | 1 | Value selection for a base register stored in predecrement mode |
| cfg_restricted | input | 1 | Reduced instruction set: longword only, modes 2 and 5 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle illegal-combination pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_long | output | 1 | Longword (1) or word (0) access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Load data (word in bits 15:0) |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |

## Verification
The hardest case to reach is a predecrement store in which the base register is itself in the mask. Its stored value depends on the configuration input, and it must not be confused with the decremented address or with the value written back at the end. The bench sets the base register to the same value as `ea` and places it between two other selected registers, so that at least one store comes before it. It then runs the same mask twice, with the configuration input low and then high and with the two transfer sizes. It checks every stored address and value, and the final write-back.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [2:0] MODE_DREG = 3'd0;
  localparam logic [2:0] MODE_AREG = 3'd1;
  localparam logic [2:0] MODE_IND  = 3'd2;
  localparam logic [2:0] MODE_POST = 3'd3;
  localparam logic [2:0] MODE_PRE  = 3'd4;
  localparam logic [2:0] MODE_DISP = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_XFER, ST_COMMIT, ST_WB, ST_DONE
  } mrx_state_e;

  typedef struct packed {
    logic       load;
    logic       lng;
    logic [2:0] mode;
    logic [2:0] base;
  } mrx_op_t;
endpackage

// File: rtl/mrx_rst_sync.sv
module mrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mrx_decode.sv
module mrx_decode
  import mrx_pkg::*;
(
  input  logic [15:0] insn,
  input  logic        cfg_restricted,
  output mrx_op_t     op,
  output logic        illegal
);
  logic unused_insn;
  assign unused_insn = ^{insn[15:11], insn[9:7]};

  always_comb begin
    op.load = insn[10];
    op.lng  = insn[6];
    op.mode = insn[5:3];
    op.base = insn[2:0];
    illegal = 1'b0;
    if (op.mode == MODE_DREG || op.mode == MODE_AREG) illegal = 1'b1;
    if (op.mode == MODE_POST && !op.load)             illegal = 1'b1;
    if (op.mode == MODE_PRE && op.load)               illegal = 1'b1;
    if (cfg_restricted &&
        (!op.lng || !(op.mode == MODE_IND || op.mode == MODE_DISP)))
      illegal = 1'b1;
  end
endmodule

// File: rtl/mrx_pick.sv
module mrx_pick #(
  parameter int N       = 16,
  parameter bit DESCEND = 1'b0,
  parameter int IW      = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  generate
    if (DESCEND) begin : g_desc
      always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) if (vec[i]) idx = IW'(i);
      end
    end else begin : g_asc
      always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) if (vec[i]) idx = IW'(i);
      end
    end
  endgenerate

  assign any = |vec;
endmodule

// File: rtl/mrx_stage.sv
module mrx_stage #(
  parameter int N  = 16,
  parameter int W  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ent_q [N];

  always_ff @(posedge clk) begin
    if (we) ent_q[widx] <= wdata;
  end

  assign rdata = ent_q[ridx];
endmodule

// File: rtl/mrx_seq.sv
module mrx_seq
  import mrx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       insn,
  input  logic [NREG-1:0]   mask,
  input  logic [XLEN-1:0]   ea,
  input  logic              cfg_later_gen,
  input  logic              cfg_restricted,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_long,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [RIDX_W-1:0] rf_rd_idx,
  input  logic [XLEN-1:0]   rf_rd_data,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [XLEN-1:0]   rf_wr_data
);
  localparam int HALF = XLEN / 2;

  logic             rst_sync_n;
  mrx_state_e       st_q, st_d;
  mrx_op_t          op_q, dec_op;
  logic             dec_illegal;
  logic [NREG-1:0]  mask_ord;
  logic [NREG-1:0]  pend_q, pend_d, cpend_q, cpend_d;
  logic [XLEN-1:0]  addr_q, addr_d, step;
  logic             later_q, any_q, fault_q, fault_d;
  logic             accept, predec, wb_need, hit;
  logic [RIDX_W-1:0] up_idx, dn_idx, xfer_idx, c_idx, base_idx;
  logic             up_any, dn_any, c_any;
  logic [XLEN-1:0]  st_val, ld_val, stage_val;

  mrx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  mrx_decode u_dec (
    .insn(insn), .cfg_restricted(cfg_restricted),
    .op(dec_op), .illegal(dec_illegal)
  );

  // Predecrement walks hold register i at position i after reversing the mask.
  for (genvar g = 0; g < NREG; g++) begin : g_order
    assign mask_ord[g] = (dec_op.mode == MODE_PRE) ? mask[NREG-1-g] : mask[g];
  end

  mrx_pick #(.N(NREG), .DESCEND(1'b0)) u_pick_up (
    .vec(pend_q), .idx(up_idx), .any(up_any)
  );
  mrx_pick #(.N(NREG), .DESCEND(1'b1)) u_pick_dn (
    .vec(pend_q), .idx(dn_idx), .any(dn_any)
  );
  mrx_pick #(.N(NREG), .DESCEND(1'b0)) u_pick_commit (
    .vec(cpend_q), .idx(c_idx), .any(c_any)
  );

  assign predec   = (op_q.mode == MODE_PRE);
  assign step     = op_q.lng ? XLEN'(4) : XLEN'(2);
  assign xfer_idx = predec ? dn_idx : up_idx;
  assign base_idx = {1'b1, op_q.base};
  assign wb_need  = any_q && (op_q.mode == MODE_POST || predec);
  assign accept   = (st_q == ST_IDLE) && start && !dec_illegal;
  assign hit      = mem_req && mem_ack;

  // Store value: the base register may be replaced by its pre-decremented copy.
  always_comb begin
    st_val = rf_rd_data;
    if (predec && later_q && (xfer_idx == base_idx)) st_val = rf_rd_data - step;
  end

  assign ld_val = op_q.lng ? mem_rdata
                           : {{HALF{mem_rdata[HALF-1]}}, mem_rdata[HALF-1:0]};

  mrx_stage #(.N(NREG), .W(XLEN)) u_stage (
    .clk(clk), .we(hit && op_q.load), .widx(xfer_idx), .wdata(ld_val),
    .ridx(c_idx), .rdata(stage_val)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    cpend_d = cpend_q;
    addr_d  = addr_q;
    fault_d = (st_q == ST_IDLE) && start && dec_illegal;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_XFER;
          pend_d  = mask_ord;
          cpend_d = mask_ord;
          addr_d  = ea;
        end
      end
      ST_XFER: begin
        if (!up_any) begin
          if (op_q.load)    st_d = ST_COMMIT;
          else if (wb_need) st_d = ST_WB;
          else              st_d = ST_DONE;
        end else if (mem_ack) begin
          pend_d[xfer_idx] = 1'b0;
          addr_d = predec ? (addr_q - step) : (addr_q + step);
        end
      end
      ST_COMMIT: begin
        if (!c_any) st_d = wb_need ? ST_WB : ST_DONE;
        else        cpend_d[c_idx] = 1'b0;
      end
      ST_WB:   st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      cpend_q <= '0;
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      cpend_q <= cpend_d;
      addr_q  <= addr_d;
      fault_q <= fault_d;
    end
  end

  // Operation context, loaded only when an instruction is accepted
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q    <= '0;
      later_q <= 1'b0;
      any_q   <= 1'b0;
    end else if (accept) begin
      op_q    <= dec_op;
      later_q <= cfg_later_gen;
      any_q   <= |mask;
    end
  end

  logic unused_dn;
  assign unused_dn = dn_any;

  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign fault      = fault_q;
  assign mem_req    = (st_q == ST_XFER) && up_any;
  assign mem_we     = !op_q.load;
  assign mem_long   = op_q.lng;
  assign mem_addr   = predec ? (addr_q - step) : addr_q;
  assign mem_wdata  = op_q.lng ? st_val : {{HALF{1'b0}}, st_val[HALF-1:0]};
  assign rf_rd_idx  = xfer_idx;
  assign rf_we      = ((st_q == ST_COMMIT) && c_any) || (st_q == ST_WB);
  assign rf_wr_idx  = (st_q == ST_WB) ? base_idx : c_idx;
  assign rf_wr_data = (st_q == ST_WB) ? addr_q : stage_val;
endmodule

// File: rtl/mrx_seq_chk.sv
module mrx_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_long,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            mem_ack,
  input logic            rf_we
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rf_we); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy && !mem_req && !rf_we && !done); // R2
  AST_READS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !rf_we); // R6
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_long |-> mem_wdata[XLEN-1:XLEN/2] == '0); // R13
endmodule

bind mrx_seq mrx_seq_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/mrx_seq_tb_top.sv
`timescale 1ns/1ps
module mrx_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cfg_later_gen, cfg_restricted;
  logic [15:0] insn, mask;
  logic [31:0] ea;
  logic        busy, done, fault, mem_req, mem_we, mem_long, mem_ack, rf_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
  logic [3:0]  rf_rd_idx, rf_wr_idx;

  always #2.5 clk = ~clk;

  mrx_seq dut_i (.*);

  logic [15:0] mem16 [0:255];
  logic [31:0] rf [0:15];
  logic        ack_q;
  int          wcnt, stall, cyc;
  int          lg_n, rl_n, mem_last, rf_first, rf_last, done_cyc;
  logic [31:0] lg_addr [0:63];
  logic [31:0] lg_data [0:63];
  logic [3:0]  rl_idx [0:63];
  logic [31:0] rl_dat [0:63];
  int          n_chk = 0, n_bad = 0;
  bit          got_done, got_fault, post_idle, finished = 0;

  assign mem_ack    = ack_q;
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem_long ? {mem16[mem_addr[8:1]], mem16[mem_addr[8:1] + 8'd1]}
                               : {16'h0, mem16[mem_addr[8:1]]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !ack_q) begin
      if (wcnt >= stall) begin ack_q <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else ack_q <= 1'b0;
    if (mem_req && ack_q) begin
      if (lg_n < 64) begin lg_addr[lg_n] <= mem_addr; lg_data[lg_n] <= mem_wdata; end
      lg_n <= lg_n + 1;
      mem_last <= cyc;
      if (mem_we) begin
        if (mem_long) begin
          mem16[mem_addr[8:1]]        <= mem_wdata[31:16];
          mem16[mem_addr[8:1] + 8'd1] <= mem_wdata[15:0];
        end else mem16[mem_addr[8:1]] <= mem_wdata[15:0];
      end
    end
    if (rf_we) begin
      rf[rf_wr_idx] <= rf_wr_data;
      if (rl_n < 64) begin rl_idx[rl_n] <= rf_wr_idx; rl_dat[rl_n] <= rf_wr_data; end
      if (rl_n == 0) rf_first <= cyc;
      rl_n <= rl_n + 1;
      rf_last <= cyc;
    end
  end

  function automatic logic [15:0] mk(bit ld, bit lg, int md, int bs);
    logic [2:0] m3, b3;
    m3 = 3'(md);
    b3 = 3'(bs);
    return {5'b01001, ld, 3'b001, lg, m3, b3};
  endfunction

  function automatic logic [31:0] rv(int i);
    return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic init_rf();
    @(negedge clk);
    for (int i = 0; i < 16; i++) rf[i] = rv(i);
  endtask

  task automatic run_op(input logic [15:0] ins, input logic [15:0] msk, input logic [31:0] a);
    @(negedge clk);
    lg_n = 0; rl_n = 0; rf_first = -1; rf_last = -1; mem_last = -1;
    insn = ins; mask = msk; ea = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 0; got_fault = 0;
    for (int k = 0; k < 400; k++) begin
      if (done)  begin got_done = 1; done_cyc = cyc; break; end
      if (fault) begin got_fault = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    post_idle = !done && !busy && !fault;
  endtask

  task automatic t_reset();
    chk("R11 reset idle", {27'h0, busy, done, fault, mem_req, rf_we}, 32'h0);
  endtask

  task automatic t_store_asc();
    init_rf(); stall = 0;
    run_op(mk(0, 1, 2, 0), 16'h8103, 32'h40);
    chk("R5 done", {31'h0, got_done}, 32'h1);
    chk("R5 count", lg_n, 4);
    chk("R1 step addr0", lg_addr[0], 32'h40);
    chk("R1 step addr3", lg_addr[3], 32'h4C);
    chk("R5 data0", lg_data[0], rv(0));
    chk("R5 data1", lg_data[1], rv(1));
    chk("R5 data2", lg_data[2], rv(8));
    chk("R5 data3", lg_data[3], rv(15));
    chk("R5 no rf write", rl_n, 0);
    chk("R5 memory", {mem16[8'h26], mem16[8'h27]}, rv(15));
    chk("R11 idle after done", {31'h0, post_idle}, 32'h1);
  endtask

  task automatic t_store_word();
    init_rf(); stall = 2;
    run_op(mk(0, 0, 5, 1), 16'h0006, 32'h60);
    chk("R1 word count", lg_n, 2);
    chk("R1 word step", lg_addr[1], 32'h62);
    chk("R13 word data", lg_data[0], {16'h0, rv(1)[15:0]});
    chk("R13 memory", {16'h0, mem16[8'h31]}, {16'h0, rv(2)[15:0]});
    chk("R12 stalled done", {31'h0, got_done}, 32'h1);
  endtask

  task automatic t_load_post();
    init_rf(); stall = 1;
    @(negedge clk);
    mem16[8'h40] = 16'h1122; mem16[8'h41] = 16'h3344;
    mem16[8'h42] = 16'h5566; mem16[8'h43] = 16'h7788;
    run_op(mk(1, 1, 3, 2), 16'h0021, 32'h80);
    chk("R6 reads", lg_n, 2);
    chk("R6 writes", rl_n, 3);
    chk("R6 order", {31'h0, rf_first > mem_last}, 32'h1);
    chk("R6 D0", rf[0], 32'h1122_3344);
    chk("R6 D5", rf[5], 32'h5566_7788);
    chk("R7 last idx", {28'h0, rl_idx[2]}, 32'd10);
    chk("R7 base", rf[10], 32'h88);
    chk("R11 done after writes", {31'h0, done_cyc > rf_last}, 32'h1);
  endtask

  task automatic t_load_sext();
    init_rf(); stall = 0;
    @(negedge clk);
    mem16[8'h50] = 16'h8001; mem16[8'h51] = 16'h1234;
    run_op(mk(1, 0, 2, 0), 16'h0300, 32'hA0);
    chk("R6 sext neg", rf[8], 32'hFFFF_8001);
    chk("R6 sext pos", rf[9], 32'h0000_1234);
    chk("R6 no writeback", rl_n, 2);
  endtask

  task automatic t_predec(input bit later, input bit lng);
    logic [31:0] s, a0;
    init_rf(); stall = 0; cfg_later_gen = later;
    @(negedge clk);
    rf[11] = 32'hC0;
    s = lng ? 32'd4 : 32'd2;
    run_op(mk(0, lng, 4, 3), 16'h8011, 32'hC0);
    a0 = 32'hC0 - s;
    chk("R8 count", lg_n, 3);
    chk("R8 addr0", lg_addr[0], a0);
    chk("R8 addr2", lg_addr[2], a0 - 2 * s);
    chk("R8 A7 first", lg_data[0], lng ? rv(15) : {16'h0, rv(15)[15:0]});
    chk("R9 base value", lg_data[1], later ? (32'hC0 - s) : 32'hC0);
    chk("R8 D0 last", lg_data[2], lng ? rv(0) : {16'h0, rv(0)[15:0]});
    chk("R8 writeback", rf[11], 32'hC0 - 3 * s);
    chk("R8 one rf write", rl_n, 1);
    cfg_later_gen = 1'b0;
  endtask

  task automatic expect_fault(input string rq, input logic [15:0] ins);
    run_op(ins, 16'h00FF, 32'h10);
    chk(rq, {29'h0, got_fault, got_done, 1'b0}, 32'h4);
    chk(rq, lg_n + rl_n, 0);
  endtask

  task automatic t_fault_direct();
    init_rf();
    expect_fault("R2 mode0", mk(0, 1, 0, 1));
    expect_fault("R2 mode1", mk(1, 1, 1, 1));
  endtask

  task automatic t_fault_dir();
    init_rf();
    expect_fault("R3 post store", mk(0, 1, 3, 1));
    expect_fault("R3 pre load", mk(1, 1, 4, 1));
  endtask

  task automatic t_restricted();
    init_rf(); stall = 0; cfg_restricted = 1'b1;
    expect_fault("R4 word", mk(0, 0, 2, 1));
    expect_fault("R4 mode3", mk(1, 1, 3, 1));
    expect_fault("R4 mode6", mk(0, 1, 6, 1));
    run_op(mk(0, 1, 5, 1), 16'h0001, 32'h20);
    chk("R4 allowed", {30'h0, got_fault, got_done}, 32'h1);
    chk("R4 allowed count", lg_n, 1);
    cfg_restricted = 1'b0;
  endtask

  task automatic t_zero_mask();
    init_rf(); stall = 0;
    run_op(mk(1, 1, 3, 4), 16'h0000, 32'h70);
    chk("R10 post done", {31'h0, got_done}, 32'h1);
    chk("R10 post quiet", lg_n + rl_n, 0);
    chk("R10 base kept", rf[12], rv(12));
    run_op(mk(0, 0, 4, 4), 16'h0000, 32'h70);
    chk("R10 pre done", {31'h0, got_done}, 32'h1);
    chk("R10 pre quiet", lg_n + rl_n, 0);
  endtask

  task automatic t_busy_ignore();
    init_rf(); stall = 2;
    @(negedge clk);
    mem16[8'h18] = 16'hDEAD; mem16[8'h19] = 16'hBEEF;
    lg_n = 0; rl_n = 0;
    insn = mk(0, 1, 2, 0); mask = 16'h0003; ea = 32'h10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R11 busy", {31'h0, busy}, 32'h1);
    insn = mk(0, 1, 2, 0); mask = 16'h0001; ea = 32'h30; start = 1'b1;
    @(negedge clk); start = 1'b0;
    got_done = 0;
    for (int k = 0; k < 100; k++) begin
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R11 first op done", {31'h0, got_done}, 32'h1);
    chk("R11 count", lg_n, 2);
    chk("R11 addr", lg_addr[1], 32'h14);
    chk("R11 ignored start", {mem16[8'h18], mem16[8'h19]}, 32'hDEAD_BEEF);
    chk("R11 stays idle", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; insn = '0; mask = '0; ea = '0;
    cfg_later_gen = 1'b0; cfg_restricted = 1'b0;
    ack_q = 1'b0; wcnt = 0; stall = 0; cyc = 0;
    lg_n = 0; rl_n = 0;
    for (int i = 0; i < 256; i++) mem16[i] = 16'h0;
    for (int i = 0; i < 16; i++) rf[i] = rv(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_store_asc();
    t_store_word();
    t_load_post();
    t_load_sext();
    t_predec(1'b0, 1'b1);
    t_predec(1'b1, 1'b0);
    t_fault_direct();
    t_fault_dir();
    t_restricted();
    t_zero_mask();
    t_busy_ignore();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule